// File: doc/BRIEF.md
# Dual-Port Memory with Same-Address Contention Arbiter

This block is a clocked model of a two-sided memory, 2048 words of 8 bits by default. The left and right sides each carry their own active-low select, write strobe and read-drive enable, plus an address and a data path. Both sides may touch any word in the same cycle. When both select the same word, an arbiter picks one winner. The losing side's write is dropped, and its active-low busy flag goes low on the following edge.

For wider words, several copies run side by side. One copy, with `slave_role` low, arbitrates and drives its busy flags outward. The other copies run with `slave_role` high: their busy pins become inputs fed from the arbitrating copy, and a low input suppresses that side's write. Every pin is a plain level-sampled control or data pin; there is no valid/ready stream at the edge, because each access is a single-cycle memory strobe that is never held off. The data bus tristate is modelled as a drive flag.

Top module: `dpr_collide_top`

## Requirements
- R1: A side with `cs_n`=0 and `we_n`=0 writes `wdata` to `addr` at the clock edge unless it is blocked. A side with `cs_n`=0 and `we_n`=1 loads the word at `addr` into `rdata` at the edge. A read sees the value held before any write at the same edge.
- R2: Both sides reading one address in the same cycle both receive the stored word.
- R3: In arbitrating mode, when both sides are selected on equal addresses, the losing side's `busy_n_o` is 0 after the next edge. It stays 0 while the contention lasts.
- R4: When both sides reach the same address in the same cycle with no prior claim, the left side wins and only `r_busy_n_o` goes low. The two busy outputs are never low together.
- R5: A write from the losing side leaves the memory unchanged. The block applies this in the same cycle the contention is detected.
- R6: A side that was already selected on an address in the previous cycle keeps priority over a side that arrives later. It keeps that priority for as long as it stays selected on that address.
- R7: A read from the losing side still loads the stored word into its `rdata`.
- R8: Both busy outputs are 1 one edge after the addresses differ or either side is deselected.
- R9: A side with `cs_n`=1 takes no part in arbitration. Its `drive` is 0 after the edge. `drive` is 1 after an edge only if that side read with `oe_n`=0.
- R10: With `slave_role`=1, both busy outputs stay 1. A side's write is suppressed while its `busy_n_i` is 0 and goes through while it is 1. Reads are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_role | input | 1 | 1: busy pins act as write-gating inputs; 0: arbitrate locally |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write strobe, active low (1 = read) |
| l_oe_n | input | 1 | Left read-drive enable, active low |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_busy_n_i | input | 1 | Left write gate in slave role, active low |
| l_rdata | output | 8 | Left read data |
| l_drive | output | 1 | Left data bus driven |
| l_busy_n_o | output | 1 | Left lost arbitration, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write strobe, active low (1 = read) |
| r_oe_n | input | 1 | Right read-drive enable, active low |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_busy_n_i | input | 1 | Right write gate in slave role, active low |
| r_rdata | output | 8 | Right read data |
| r_drive | output | 1 | Right data bus driven |
| r_busy_n_o | output | 1 | Right lost arbitration, active low |

## Verification
A wrong owner record inside the arbiter shows up as a busy flag on the wrong side one edge after the collision. It also shows as a word later read back with the loser's value instead of the winner's, so it is visible within two cycles. A stale claim shows as a busy flag that stays low on the idle cycle after contention ends. The bench sweeps every address pair of a 16-word instance, so each equal and unequal pair is seen at the ports. Slave gating appears as words that did or did not change when read on the opposite side.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_act,
  input  logic          r_act,
  input  logic [AW-1:0] l_addr,
  input  logic [AW-1:0] r_addr,
  output logic          match,
  output logic          lose_l,
  output logic          lose_r,
  output logic          busy_l,
  output logic          busy_r
);
  logic          l_was, r_was;
  logic [AW-1:0] l_prev, r_prev;
  owner_e        win_q, win_d;
  logic          l_hold, r_hold;

  assign l_hold = l_act && l_was && (l_addr == l_prev);
  assign r_hold = r_act && r_was && (r_addr == r_prev);
  assign match  = l_act && r_act && (l_addr == r_addr);

  // Priority: existing owner keeps it, else the earlier arrival, else left.
  always_comb begin
    if (!match)                          win_d = OWN_NONE;
    else if (win_q == OWN_LEFT  && l_hold) win_d = OWN_LEFT;
    else if (win_q == OWN_RIGHT && r_hold) win_d = OWN_RIGHT;
    else if (r_hold && !l_hold)          win_d = OWN_RIGHT;
    else                                 win_d = OWN_LEFT;
  end

  assign lose_l = match && (win_d == OWN_RIGHT);
  assign lose_r = match && (win_d == OWN_LEFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_was  <= 1'b0;
      r_was  <= 1'b0;
      l_prev <= '0;
      r_prev <= '0;
      win_q  <= OWN_NONE;
      busy_l <= 1'b0;
      busy_r <= 1'b0;
    end else begin
      l_was  <= l_act;
      r_was  <= r_act;
      l_prev <= l_addr;
      r_prev <= r_addr;
      win_q  <= win_d;
      busy_l <= lose_l;
      busy_r <= lose_r;
    end
  end

  // R4: at most one side flagged
  a_r4_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_l && busy_r));
  // R6: a left winner that stays on its address keeps beating the right side
  a_r6_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $past(lose_r) && l_hold) |-> lose_r);
endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_l,
  input  logic [AW-1:0] a_l,
  input  logic [DW-1:0] d_l,
  input  logic          wr_r,
  input  logic [AW-1:0] a_r,
  input  logic [DW-1:0] d_r,
  output logic [DW-1:0] q_l,
  output logic [DW-1:0] q_r
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  assign q_l = mem[a_l];
  assign q_r = mem[a_r];

  always_ff @(posedge clk) begin
    if (wr_r) mem[a_r] <= d_r;
    if (wr_l) mem[a_l] <= d_l;
  end
endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          oe_en,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] rdata,
  output logic          drive
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      drive <= 1'b0;
    end else begin
      drive <= rd_en && oe_en;
      if (rd_en) rdata <= word;
    end
  end
endmodule

// File: rtl/dpr_collide_top.sv
module dpr_collide_top #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_role,
  input  logic          l_cs_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          l_busy_n_i,
  output logic [DW-1:0] l_rdata,
  output logic          l_drive,
  output logic          l_busy_n_o,
  input  logic          r_cs_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  input  logic          r_busy_n_i,
  output logic [DW-1:0] r_rdata,
  output logic          r_drive,
  output logic          r_busy_n_o
);
  localparam int NSIDE = 2;

  logic          l_act, r_act;
  logic          match, lose_l, lose_r, busy_l, busy_r;
  logic          wr_l, wr_r;
  logic [DW-1:0] q_l, q_r;

  assign l_act = !l_cs_n;
  assign r_act = !r_cs_n;

  dpr_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n), .l_act(l_act), .r_act(r_act),
    .l_addr(l_addr), .r_addr(r_addr), .match(match),
    .lose_l(lose_l), .lose_r(lose_r), .busy_l(busy_l), .busy_r(busy_r)
  );

  assign wr_l = l_act && !l_we_n && (slave_role ? l_busy_n_i : !lose_l);
  assign wr_r = r_act && !r_we_n && (slave_role ? r_busy_n_i : !lose_r);

  assign l_busy_n_o = slave_role || !busy_l;
  assign r_busy_n_o = slave_role || !busy_r;

  dpr_store #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .wr_l(wr_l), .a_l(l_addr), .d_l(l_wdata),
    .wr_r(wr_r), .a_r(r_addr), .d_r(r_wdata), .q_l(q_l), .q_r(q_r)
  );

  logic [NSIDE-1:0]   rd_en_v, oe_v, drive_v;
  logic [DW-1:0]      word_v  [NSIDE];
  logic [DW-1:0]      rdata_v [NSIDE];

  assign rd_en_v = {r_act && r_we_n, l_act && l_we_n};
  assign oe_v    = {!r_oe_n, !l_oe_n};
  assign word_v[0] = q_l;
  assign word_v[1] = q_r;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dpr_port_out #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en_v[s]), .oe_en(oe_v[s]),
      .word(word_v[s]), .rdata(rdata_v[s]), .drive(drive_v[s])
    );
  end

  assign l_rdata = rdata_v[0];
  assign r_rdata = rdata_v[1];
  assign l_drive = drive_v[0];
  assign r_drive = drive_v[1];

  // R3: a right-side loss is flagged on the next edge
  a_r3_flag_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_role && lose_r) |=> (!r_busy_n_o || slave_role));
  // R8: no contention means both flags clear one edge later
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> (l_busy_n_o && r_busy_n_o));
  // R5: never two writes into one word in arbitrating mode
  a_r5_single_writer: assert property (@(posedge clk) disable iff (!rst_n || slave_role)
    !(wr_l && wr_r && (l_addr == r_addr)));
  // R9: a deselected side does not drive its bus after the edge
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    l_cs_n |=> !l_drive);
endmodule

// File: tb/sim_dpr_collide_top.sv
`timescale 1ns/1ps
module sim_dpr_collide_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_role = 1'b0;
  logic l_cs_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1, l_busy_n_i = 1'b1;
  logic r_cs_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1, r_busy_n_i = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_drive, r_drive, l_busy_n_o, r_busy_n_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_m [N];

  always #4 clk = ~clk;

  dpr_collide_top #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .slave_role(slave_role),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_busy_n_i(l_busy_n_i), .l_rdata(l_rdata),
    .l_drive(l_drive), .l_busy_n_o(l_busy_n_o),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_busy_n_i(r_busy_n_i), .r_rdata(r_rdata),
    .r_drive(r_drive), .r_busy_n_o(r_busy_n_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drv_l(input logic cs, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_cs_n = cs; l_we_n = we; l_oe_n = oe; l_addr = a; l_wdata = d;
  endtask

  task automatic drv_r(input logic cs, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_cs_n = cs; r_we_n = we; r_oe_n = oe; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    drv_l(1'b1, 1'b1, 1'b1, '0, '0);
    drv_r(1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  // read ra on left and rb on right, compare against the model
  task automatic read_pair(input logic [AW-1:0] ra, input logic [AW-1:0] rb, input string req);
    drv_l(1'b0, 1'b1, 1'b0, ra, '0);
    drv_r(1'b0, 1'b1, 1'b0, rb, '0);
    tick();
    chk(req, l_rdata, ref_m[ra]);
    chk(req, r_rdata, ref_m[rb]);
    idle();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) tick();
    // reset state
    chk("R8 reset l_busy", {7'd0, l_busy_n_o}, 8'd1);
    chk("R8 reset r_busy", {7'd0, r_busy_n_o}, 8'd1);
    chk("R9 reset drive", {6'd0, l_drive, r_drive}, 8'd0);
    chk("R1 reset rdata", l_rdata | r_rdata, 8'd0);
    rst_n = 1'b1;
    tick();

    // R1: fill from the left, read back from the right
    for (int a = 0; a < N; a++) begin
      drv_l(1'b0, 1'b0, 1'b1, a[AW-1:0], 8'((a * 7) + 3));
      ref_m[a] = 8'((a * 7) + 3);
      tick();
    end
    idle();
    tick();
    for (int a = 0; a < N; a++) begin
      drv_r(1'b0, 1'b1, 1'b0, a[AW-1:0], '0);
      tick();
      chk("R1 readback", r_rdata, ref_m[a]);
      chk("R9 drive on read", {7'd0, r_drive}, 8'd1);
    end
    idle();
    tick();

    // R2: both sides read the same word together
    for (int a = 0; a < N; a++) read_pair(a[AW-1:0], a[AW-1:0], "R2 shared read");

    // R3 R4 R5 R8: every address pair, both sides writing together from idle
    for (int la = 0; la < N; la++) begin
      for (int ra = 0; ra < N; ra++) begin
        logic [DW-1:0] vl, vr;
        vl = 8'((la << 4) | ra);
        vr = ~vl;
        drv_l(1'b0, 1'b0, 1'b1, la[AW-1:0], vl);
        drv_r(1'b0, 1'b0, 1'b1, ra[AW-1:0], vr);
        tick();
        chk("R4 left never flagged on tie", {7'd0, l_busy_n_o}, 8'd1);
        chk("R3 right flag on equal address", {7'd0, r_busy_n_o}, (la == ra) ? 8'd0 : 8'd1);
        if (la != ra) ref_m[ra] = vr;
        ref_m[la] = vl;
        idle();
        tick();
        chk("R8 release after idle", {6'd0, l_busy_n_o, r_busy_n_o}, 8'd3);
        read_pair(ra[AW-1:0], la[AW-1:0], "R5 memory after collision");
      end
    end

    // R6: right holds word 5, left arrives later writing it
    drv_r(1'b0, 1'b1, 1'b0, 4'd5, '0);
    tick();
    drv_l(1'b0, 1'b0, 1'b1, 4'd5, 8'hAA);
    tick();
    chk("R6 late left flagged", {7'd0, l_busy_n_o}, 8'd0);
    chk("R6 holder not flagged", {7'd0, r_busy_n_o}, 8'd1);
    chk("R6 holder reads old word", r_rdata, ref_m[5]);
    tick();
    chk("R3 flag held while contended", {7'd0, l_busy_n_o}, 8'd0);
    // holder moves away: left write goes through, flag clears
    drv_r(1'b0, 1'b1, 1'b0, 4'd6, '0);
    tick();
    ref_m[5] = 8'hAA;
    chk("R8 release on address change", {7'd0, l_busy_n_o}, 8'd1);
    idle();
    tick();
    read_pair(4'd5, 4'd6, "R5 late write after release");

    // R7: left holds word 9, right reads it as loser
    drv_l(1'b0, 1'b0, 1'b1, 4'd9, 8'h3C);
    tick();
    ref_m[9] = 8'h3C;
    drv_l(1'b0, 1'b1, 1'b1, 4'd9, '0);
    drv_r(1'b0, 1'b1, 1'b0, 4'd9, '0);
    tick();
    chk("R7 loser flagged", {7'd0, r_busy_n_o}, 8'd0);
    chk("R7 loser read data", r_rdata, 8'h3C);
    // loser attempts a write while still contended
    drv_r(1'b0, 1'b0, 1'b1, 4'd9, 8'hE1);
    tick();
    idle();
    tick();
    read_pair(4'd9, 4'd9, "R5 loser write dropped");

    // R9: deselected left on the same address does not contend
    drv_l(1'b1, 1'b1, 1'b0, 4'd3, '0);
    drv_r(1'b0, 1'b0, 1'b1, 4'd3, 8'h5C);
    tick();
    ref_m[3] = 8'h5C;
    chk("R9 no flag when deselected", {6'd0, l_busy_n_o, r_busy_n_o}, 8'd3);
    chk("R9 deselected no drive", {7'd0, l_drive}, 8'd0);
    drv_r(1'b1, 1'b1, 1'b1, '0, '0);
    drv_l(1'b0, 1'b1, 1'b1, 4'd3, '0);
    tick();
    chk("R9 oe high no drive", {7'd0, l_drive}, 8'd0);
    chk("R1 data captured with oe high", l_rdata, 8'h5C);
    drv_l(1'b0, 1'b0, 1'b0, 4'd4, 8'h44);
    tick();
    ref_m[4] = 8'h44;
    chk("R9 write no drive", {7'd0, l_drive}, 8'd0);
    idle();
    tick();

    // R10: slave role gating
    slave_role = 1'b1;
    l_busy_n_i = 1'b0;
    r_busy_n_i = 1'b1;
    drv_l(1'b0, 1'b0, 1'b1, 4'd2, 8'h11);
    drv_r(1'b0, 1'b0, 1'b1, 4'd4, 8'h22);
    tick();
    ref_m[4] = 8'h22;
    drv_l(1'b0, 1'b1, 1'b0, 4'd7, '0);
    drv_r(1'b0, 1'b1, 1'b0, 4'd7, '0);
    l_busy_n_i = 1'b1;
    tick();
    chk("R10 outputs high in slave role", {6'd0, l_busy_n_o, r_busy_n_o}, 8'd3);
    tick();
    chk("R10 outputs stay high on match", {6'd0, l_busy_n_o, r_busy_n_o}, 8'd3);
    idle();
    tick();
    read_pair(4'd2, 4'd4, "R10 gated and open writes");
    drv_l(1'b0, 1'b0, 1'b1, 4'd2, 8'h77);
    tick();
    ref_m[2] = 8'h77;
    idle();
    tick();
    read_pair(4'd2, 4'd2, "R10 write with gate open");
    slave_role = 1'b0;
    tick();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule